// File: doc/BRIEF.md
# ADC Alarm Interrupt Control Register

This block is one 8-bit control and status register for an external analog-to-digital converter. The host writes it through a plain strobe-and-data port and reads it back on a combinational read bus. The register holds three things. A 3-bit field picks which of the legacy interrupt request lines the alarm interrupt uses. A control bit drives the converter's reset pin. An enable bit gates the interrupt.

The converter's alarm pin arrives asynchronously. It passes through a synchronizer, and the synchronized level can be read back. A low-to-high change of that level latches a sticky status bit, which the host clears by writing a one to it. While both the status bit and the enable bit are set, exactly one line of a 16-bit interrupt vector is driven. The line is the one the select field maps to. The reset pin gets a hardware minimum pulse width, so even a very short software pulse lasts long enough for the converter. The pin is also asserted during and just after a platform reset.

Top module: `adc_alarm_ctl`

## Requirements
- R1: While `rst_n` is low and after it rises, `rd_data` reads 0x00 with the alarm input low, and `irq_o` is all zero.
- R2: A write stores bits 6:4 (line select), bit 3 (converter reset control) and bit 0 (interrupt enable), and each reads back in the same position. Bit 7 always reads 0 and ignores writes.
- R3: Bit 2 reads the alarm input level through a two-stage synchronizer. A change on `alarm_in` becomes visible after the second rising clock edge.
- R4: Bit 1 (alarm status) becomes 1 at the third rising edge after `alarm_in` goes from low to high. An alarm that stays high does not set it again after it is cleared.
- R5: A write with bit 1 = 1 clears the status bit. A write with bit 1 = 0 leaves it unchanged.
- R6: When a detected rising edge and a clearing write fall in the same cycle, the status bit ends as 1.
- R7: When status and enable are both 1, `irq_o` has exactly one bit set, at the line index the select value maps to: 0→3, 1→4, 2→5, 3→10, 4→6, 5→7, 6→9, 7→11. Otherwise `irq_o` is zero.
- R8: `adc_rst_o` is 1 while bit 3 is 1. After bit 3 is cleared, it stays 1 for RST_MIN_CYCLES more samples, starting with the cycle in which the clear takes effect.
- R9: `adc_rst_o` is 1 while `rst_n` is low. It stays 1 for RST_MIN_CYCLES samples counted from the release of `rst_n`, including the release cycle itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low platform reset |
| wr_en | input | 1 | Write strobe for the register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register read value |
| alarm_in | input | 1 | Asynchronous converter alarm pin |
| adc_rst_o | output | 1 | Converter reset pin, active high, pulse-stretched |
| irq_o | output | 16 | One-hot legacy interrupt request lines |

## Verification
The mapping is swept over all eight select values, with the enable both on and off. This separates a wrong line index from a missing gate. The alarm is driven in four ways: a single rise, a steady high after clearing, a rise whose detection coincides with a clearing write, and a write of zero to the status bit. Together these separate edge detection from level detection and show the priority of set over clear. The reset pin is measured in three cases: a one-cycle software pulse, a long software pulse, and the release of platform reset. This shows that the stretch counts from the clear, not from the set.

// File: rtl/adc_alarm_pkg.sv
// Package: shared constants and the select-to-line mapping for the alarm
// interrupt register. Assumes a 16-line legacy interrupt vector.
package adc_alarm_pkg;
    localparam int REG_W    = 8;
    localparam int SEL_W    = 3;
    localparam int LINE_W   = 4;
    localparam int SEL_LSB  = 4;
    localparam int RST_BIT  = 3;
    localparam int LVL_BIT  = 2;
    localparam int STAT_BIT = 1;
    localparam int MASK_BIT = 0;

    // Maps the 3-bit select code onto its non-monotonic line number.
    function automatic logic [LINE_W-1:0] line_of_sel(input logic [SEL_W-1:0] sel);
        logic [LINE_W-1:0] n;
        case (sel)
            3'd0: n = 4'd3;
            3'd1: n = 4'd4;
            3'd2: n = 4'd5;
            3'd3: n = 4'd10;
            3'd4: n = 4'd6;
            3'd5: n = 4'd7;
            3'd6: n = 4'd9;
            default: n = 4'd11;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/alarm_sync.sv
// alarm_sync: multi-stage synchronizer for an asynchronous level.
// Assumes the input is a slow level; no pulse shorter than a clock is kept.
module alarm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
// rst_stretch: holds its output high while the request is high and for
// MIN_CYCLES cycles after it drops, and also through and after reset.
// Assumes MIN_CYCLES >= 1.
module rst_stretch #(
    parameter int MIN_CYCLES = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);
    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(MIN_CYCLES);

    logic [CW-1:0] remain;

    // Reload while reset or the request is active, then count down.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= LOAD;
        else if (req_i)          remain <= LOAD;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign pulse_o = req_i || (remain != '0);

    // R8
    hold_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_i) |-> pulse_o);
endmodule

// File: rtl/irq_route.sv
// irq_route: drives one line of a legacy interrupt vector, chosen by a
// select code through the package mapping. Assumes LINES >= 12.
module irq_route
    import adc_alarm_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             req_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [LINES-1:0] lines_o
);
    logic [LINE_W-1:0] target;

    // Translate the select code into a line number.
    always_comb target = line_of_sel(sel_i);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines_o[i] = req_i && (target == LINE_W'(i));
    end
endmodule

// File: rtl/adc_alarm_ctl.sv
// adc_alarm_ctl: control/status register for a converter alarm and reset.
// Fields: [6:4] line select, [3] converter reset, [2] alarm level (RO),
// [1] alarm status (write one to clear), [0] interrupt enable; [7] reads 0.
// Assumes the address decode is done outside and wr_en is one cycle per write.
module adc_alarm_ctl
    import adc_alarm_pkg::*;
#(
    parameter int RST_MIN_CYCLES = 14,
    parameter int SYNC_STAGES    = 2,
    parameter int IRQ_LINES      = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 alarm_in,
    output logic                 adc_rst_o,
    output logic [IRQ_LINES-1:0] irq_o
);
    logic [SEL_W-1:0] sel_q;
    logic             rst_q;
    logic             mask_q;
    logic             stat_q;
    logic             lvl;
    logic             lvl_prev;
    logic             rise;
    logic             clr;

    alarm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(alarm_in),
        .sync_o (lvl)
    );

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= 1'b0;
        else        lvl_prev <= lvl;
    end

    assign rise = lvl && !lvl_prev;
    assign clr  = wr_en && wr_data[STAT_BIT];

    // Store the writable control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            rst_q  <= 1'b0;
            mask_q <= 1'b0;
        end else if (wr_en) begin
            sel_q  <= wr_data[SEL_LSB +: SEL_W];
            rst_q  <= wr_data[RST_BIT];
            mask_q <= wr_data[MASK_BIT];
        end
    end

    // Sticky alarm status: a rising edge sets it and wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    stat_q <= 1'b0;
        else if (rise) stat_q <= 1'b1;
        else if (clr)  stat_q <= 1'b0;
    end

    // Assemble the read value from the fields.
    always_comb begin
        rd_data                       = '0;
        rd_data[SEL_LSB +: SEL_W]     = sel_q;
        rd_data[RST_BIT]              = rst_q;
        rd_data[LVL_BIT]              = lvl;
        rd_data[STAT_BIT]             = stat_q;
        rd_data[MASK_BIT]             = mask_q;
    end

    rst_stretch #(.MIN_CYCLES(RST_MIN_CYCLES)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (rst_q),
        .pulse_o(adc_rst_o)
    );

    irq_route #(.LINES(IRQ_LINES)) u_route (
        .req_i  (stat_q && mask_q),
        .sel_i  (sel_q),
        .lines_o(irq_o)
    );

    // R7
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));
    // R4
    stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> stat_q);
    // R5
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr) |=> stat_q);
    // R8
    rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> adc_rst_o);
endmodule

// File: tb/adc_alarm_ctl_test.sv
// Bench for adc_alarm_ctl: drives on falling edges, samples on falling edges.
module adc_alarm_ctl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NMIN       = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        alarm_in = 1'b0;
    logic        adc_rst_o;
    logic [15:0] irq_o;
    int          tests = 0;
    int          fails = 0;

    adc_alarm_ctl #(.RST_MIN_CYCLES(NMIN)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .alarm_in(alarm_in), .adc_rst_o(adc_rst_o),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_line(input int s);
        case (s)
            0: return 3;  1: return 4;  2: return 5;  3: return 10;
            4: return 6;  5: return 7;  6: return 9;  default: return 11;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts consecutive high samples of adc_rst_o from the current one.
    task automatic count_high(output int n);
        n = 0;
        while (adc_rst_o && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        tick(3);
        check("R1 rd in reset", rd_data, 8'h00);
        check("R9 rst pin in reset", adc_rst_o, 1'b1);
        rst_n = 1'b1;
        count_high(n);
        check("R9 rst pin after release", n, NMIN);
        check("R1 rd after reset", rd_data, 8'h00);
        check("R1 irq after reset", irq_o, 16'h0);

        // R2 field readback, bit 7 ignored
        wr(8'hF1);
        check("R2 readback", rd_data, 8'h71);
        wr(8'h80);
        check("R2 reserved bit", rd_data, 8'h00);
        tick(NMIN + 2);

        // R3 and R4 alarm path
        alarm_in = 1'b1;
        tick(2);
        check("R3 level after two edges", rd_data[2], 1'b1);
        check("R4 status not yet", rd_data[1], 1'b0);
        tick(1);
        check("R4 status set", rd_data[1], 1'b1);

        // R5 write zero keeps status, write one clears
        wr(8'h00);
        check("R5 write zero", rd_data[1], 1'b1);
        wr(8'h02);
        check("R5 clear", rd_data[1], 1'b0);
        tick(5);
        check("R4 steady high no reset", rd_data[1], 1'b0);

        // R6 set wins over clear
        alarm_in = 1'b0;
        tick(4);
        alarm_in = 1'b1;
        tick(2);
        wr(8'h02);
        check("R6 set wins", rd_data[1], 1'b1);

        // R7 sweep of all select codes with enable on and off
        for (int s = 0; s < 8; s++) begin
            wr(8'((s << 4) | 1));
            check("R7 routed line", irq_o, 16'(1 << exp_line(s)));
            wr(8'(s << 4));
            check("R7 masked", irq_o, 16'h0);
        end
        wr(8'h03);
        check("R7 cleared status", irq_o, 16'h0);

        // R8 short and long software pulses
        wr(8'h08);
        check("R8 high while set", adc_rst_o, 1'b1);
        wr(8'h00);
        count_high(n);
        check("R8 short pulse stretch", n, NMIN);
        wr(8'h08);
        tick(30);
        check("R8 long pulse held", adc_rst_o, 1'b1);
        wr(8'h00);
        count_high(n);
        check("R8 long pulse stretch", n, NMIN);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule